// File: doc/BRIEF.md
# Processor Status and Interrupt Gating Unit

This unit holds the 16-bit processor status word of an 8-bit CPU core. The upper byte carries the register-bank selector and the lower byte carries the condition flags, the interrupt enable and the current interrupt level. After each ALU operation the unit works out the half-carry, negative, zero, overflow and carry flags from the operands, the result and an operation class. Per-flag write enables decide which of these flags are committed, so an instruction leaves the flags it does not affect unchanged.

The same word controls interrupt acceptance. A pending request with a 2-bit level is taken only when interrupts are enabled and the request outranks the current level. Taking it raises the current level to the request's level. A third path turns the bank selector and a 3-bit register index into the byte address of a general-purpose register in data memory. Software-style writes of the whole word go through a load port that has priority over every other update.

Top module: `psw_unit`

## Requirements
- R1: After reset the status word reads 0x0030: bank 0, interrupts disabled (I=0), level field 3, and H, N, Z, V and C all 0.
- R2: Status word layout: bits 12..8 bank selector, bit 7 H, bit 6 I, bits 5..4 level, bit 3 N, bit 2 Z, bit 1 V, bit 0 C. Bits 15..13 always read 0. A load stores every other bit of the load data, visible on the clock edge after the load.
- R3: Class 0 (add) and class 1 (add with carry, which adds the current C) set C on a carry out of bit 7, H on a carry from bit 3 into bit 4, and V on two's-complement overflow.
- R4: Class 2 (subtract) and class 3 (subtract with borrow, which also subtracts the current C) set C on a borrow out of bit 7, H on a borrow out of bit 4 into bit 3, and V on two's-complement overflow.
- R5: For every class N takes bit 7 of the result and Z is set when the result is 0.
- R6: Class 4 (shift left) puts operand bit 7 into C; class 5 (shift right) puts operand bit 0 into C; both clear H and V. Classes 6 and 7 (logic) clear H, V and C.
- R7: Flag write enable bits are bit 4 H, bit 3 N, bit 2 Z, bit 1 V, bit 0 C. A flag whose enable is 0 keeps its value, and ALU updates never change the bank selector, I or the level field.
- R8: irq_take is 1, in the same cycle, exactly when a request is present, I=1, no load is presented, and the request level is numerically smaller than the level field. A request that is not taken changes no state.
- R9: On the edge after a taken request the level field holds the taken request's level; flag updates in the same cycle still apply.
- R10: A load presented in the same cycle as a request blocks acceptance (irq_take=0), and the loaded value wins.
- R11: reg_addr equals 0x0100 + 8 × bank selector + register index, so bank 31 index 7 maps to 0x01FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_cls | input | 3 | Operation class of the current ALU step |
| alu_a | input | 8 | First ALU operand |
| alu_b | input | 8 | Second ALU operand |
| alu_res | input | 8 | ALU result |
| flag_we | input | 5 | Per-flag write enables {H,N,Z,V,C} |
| ps_load | input | 1 | Load the whole status word |
| ps_wdata | input | 16 | Data for a status word load |
| irq_req | input | 1 | Interrupt request pending |
| irq_lvl | input | 2 | Level of the pending request (0 highest) |
| reg_idx | input | 3 | General-purpose register index |
| ps_out | output | 16 | Current status word |
| irq_take | output | 1 | Pending request is accepted this cycle |
| reg_addr | output | 16 | Data memory address of the selected register |

## Verification
The bench builds the unit with its default parameters: an 8-bit data path, a 5-bit bank selector and a 3-bit register index. These values put the nibble carry and borrow boundary at bits 3 and 4 and the signed overflow cases at 0x7F and 0x80 within a few directed operations. They also make the full bank range reachable, from the first register at 0x0100 up to the last one at 0x01FF, and let a load show that bits 15..13 of the word are dropped.

// File: rtl/psw_pkg.sv
package psw_pkg;

    typedef enum logic [2:0] {
        CLS_ADD   = 3'd0,
        CLS_ADC   = 3'd1,
        CLS_SUB   = 3'd2,
        CLS_SBC   = 3'd3,
        CLS_SHL   = 3'd4,
        CLS_SHR   = 3'd5,
        CLS_LOGIC = 3'd6,
        CLS_LOG2  = 3'd7
    } alu_cls_e;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    localparam int WE_H = 4;
    localparam int WE_N = 3;
    localparam int WE_Z = 2;
    localparam int WE_V = 1;
    localparam int WE_C = 0;

endpackage

// File: rtl/psw_flag_calc.sv
module psw_flag_calc
    import psw_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [2:0]    cls_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic [DW-1:0] res_i,
    input  logic          c_in_i,
    output flags_t        flags_o
);
    localparam int HB = DW / 2;

    alu_cls_e    cls;
    logic        use_c;
    logic [DW:0] add_full;
    logic [DW:0] sub_full;
    logic [HB:0] add_low;
    logic [HB:0] sub_low;

    always_comb begin
        cls      = alu_cls_e'(cls_i);
        use_c    = ((cls == CLS_ADC) || (cls == CLS_SBC)) ? c_in_i : 1'b0;
        add_full = {1'b0, a_i} + {1'b0, b_i} + {{DW{1'b0}}, use_c};
        sub_full = {1'b0, a_i} - {1'b0, b_i} - {{DW{1'b0}}, use_c};
        add_low  = {1'b0, a_i[HB-1:0]} + {1'b0, b_i[HB-1:0]} + {{HB{1'b0}}, use_c};
        sub_low  = {1'b0, a_i[HB-1:0]} - {1'b0, b_i[HB-1:0]} - {{HB{1'b0}}, use_c};

        flags_o   = '0;
        flags_o.n = res_i[DW-1];
        flags_o.z = (res_i == '0);
        case (cls)
            CLS_ADD, CLS_ADC: begin
                flags_o.c = add_full[DW];
                flags_o.h = add_low[HB];
                flags_o.v = (a_i[DW-1] == b_i[DW-1]) && (res_i[DW-1] != a_i[DW-1]);
            end
            CLS_SUB, CLS_SBC: begin
                flags_o.c = sub_full[DW];
                flags_o.h = sub_low[HB];
                flags_o.v = (a_i[DW-1] != b_i[DW-1]) && (res_i[DW-1] != a_i[DW-1]);
            end
            CLS_SHL: flags_o.c = a_i[DW-1];
            CLS_SHR: flags_o.c = a_i[0];
            default: ;
        endcase
    end

endmodule

// File: rtl/psw_irq_gate.sv
module psw_irq_gate #(
    parameter int LVL_W = 2
) (
    input  logic             req_i,
    input  logic [LVL_W-1:0] lvl_i,
    input  logic             ie_i,
    input  logic [LVL_W-1:0] cur_lvl_i,
    output logic             grant_o
);
    always_comb begin
        grant_o = req_i && ie_i && (lvl_i < cur_lvl_i);
    end

endmodule

// File: rtl/psw_reg_addr.sv
module psw_reg_addr #(
    parameter int          BANK_W = 5,
    parameter int          IDX_W  = 3,
    parameter int          AW     = 16,
    parameter logic [15:0] BASE   = 16'h0100
) (
    input  logic [BANK_W-1:0] bank_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [AW-1:0]     addr_o
);
    localparam int          PAD     = AW - BANK_W - IDX_W;
    localparam logic [AW:0] SPAN    = (AW+1)'(1) << (BANK_W + IDX_W);
    localparam logic [AW:0] BASE_X  = (AW+1)'(BASE);

    always_comb begin
        addr_o = AW'(BASE) + {{PAD{1'b0}}, bank_i, idx_i};
    end

    always_comb begin
        if (!$isunknown({bank_i, idx_i})) begin
            assert_addr_window_R11: assert (({1'b0, addr_o} >= BASE_X) &&
                                            ({1'b0, addr_o} <  BASE_X + SPAN))
                else $error("register address outside the register window");
        end
    end

endmodule

// File: rtl/psw_unit.sv
module psw_unit
    import psw_pkg::*;
#(
    parameter int          DW       = 8,
    parameter int          BANK_W   = 5,
    parameter int          IDX_W    = 3,
    parameter int          AW       = 16,
    parameter logic [15:0] REG_BASE = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        alu_cls,
    input  logic [DW-1:0]     alu_a,
    input  logic [DW-1:0]     alu_b,
    input  logic [DW-1:0]     alu_res,
    input  logic [4:0]        flag_we,
    input  logic              ps_load,
    input  logic [15:0]       ps_wdata,
    input  logic              irq_req,
    input  logic [1:0]        irq_lvl,
    input  logic [IDX_W-1:0]  reg_idx,
    output logic [15:0]       ps_out,
    output logic              irq_take,
    output logic [AW-1:0]     reg_addr
);
    localparam int          LVL_W    = 2;
    localparam logic [15:0] PS_MASK  = 16'h00FF | (16'((1 << BANK_W) - 1) << 8);

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic              h;
        logic              i;
        logic [LVL_W-1:0]  il;
        logic              n;
        logic              z;
        logic              v;
        logic              c;
    } state_t;

    localparam state_t ST_RESET = '{bank: '0, h: 1'b0, i: 1'b0, il: 2'd3,
                                    n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};

    state_t st_d, st_q;
    flags_t fl;
    logic   grant;

    psw_flag_calc #(.DW(DW)) u_flags (
        .cls_i   (alu_cls),
        .a_i     (alu_a),
        .b_i     (alu_b),
        .res_i   (alu_res),
        .c_in_i  (st_q.c),
        .flags_o (fl)
    );

    psw_irq_gate #(.LVL_W(LVL_W)) u_gate (
        .req_i     (irq_req),
        .lvl_i     (irq_lvl),
        .ie_i      (st_q.i),
        .cur_lvl_i (st_q.il),
        .grant_o   (grant)
    );

    psw_reg_addr #(.BANK_W(BANK_W), .IDX_W(IDX_W), .AW(AW), .BASE(REG_BASE)) u_addr (
        .bank_i (st_q.bank),
        .idx_i  (reg_idx),
        .addr_o (reg_addr)
    );

    always_comb begin
        irq_take = grant && !ps_load;
        st_d     = st_q;
        if (ps_load) begin
            st_d.bank = ps_wdata[8 +: BANK_W];
            st_d.h    = ps_wdata[7];
            st_d.i    = ps_wdata[6];
            st_d.il   = ps_wdata[5:4];
            st_d.n    = ps_wdata[3];
            st_d.z    = ps_wdata[2];
            st_d.v    = ps_wdata[1];
            st_d.c    = ps_wdata[0];
        end else begin
            if (flag_we[WE_H]) st_d.h = fl.h;
            if (flag_we[WE_N]) st_d.n = fl.n;
            if (flag_we[WE_Z]) st_d.z = fl.z;
            if (flag_we[WE_V]) st_d.v = fl.v;
            if (flag_we[WE_C]) st_d.c = fl.c;
            if (irq_take)      st_d.il = irq_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ps_out               = '0;
        ps_out[8 +: BANK_W]  = st_q.bank;
        ps_out[7:0]          = {st_q.h, st_q.i, st_q.il, st_q.n, st_q.z, st_q.v, st_q.c};
    end

    assert_il_update_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> (ps_out[5:4] == $past(irq_lvl)))
        else $error("level field not loaded from accepted request");

    assert_load_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ps_load |=> (ps_out == ($past(ps_wdata) & PS_MASK)))
        else $error("status word load not stored as written");

    assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ps_load && !irq_take && (flag_we == 5'b0)) |=> $stable(ps_out))
        else $error("status word changed without any update");

    assert_load_blocks_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_load && irq_req) |=> (ps_out == ($past(ps_wdata) & PS_MASK)))
        else $error("request altered a word being loaded");

endmodule

// File: tb/tb_psw_unit.sv
module tb_psw_unit;

    localparam logic [2:0] C_ADD = 3'd0, C_ADC = 3'd1, C_SUB = 3'd2, C_SBC = 3'd3;
    localparam logic [2:0] C_SHL = 3'd4, C_SHR = 3'd5, C_LOG = 3'd6, C_LOG2 = 3'd7;
    localparam logic [4:0] WE_ALL = 5'h1F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  alu_cls = '0;
    logic [7:0]  alu_a = '0, alu_b = '0, alu_res = '0;
    logic [4:0]  flag_we = '0;
    logic        ps_load = 1'b0;
    logic [15:0] ps_wdata = '0;
    logic        irq_req = 1'b0;
    logic [1:0]  irq_lvl = '0;
    logic [2:0]  reg_idx = '0;
    logic [15:0] ps_out;
    logic        irq_take;
    logic [15:0] reg_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    psw_unit dut (
        .clk(clk), .rst_n(rst_n), .alu_cls(alu_cls), .alu_a(alu_a), .alu_b(alu_b),
        .alu_res(alu_res), .flag_we(flag_we), .ps_load(ps_load), .ps_wdata(ps_wdata),
        .irq_req(irq_req), .irq_lvl(irq_lvl), .reg_idx(reg_idx), .ps_out(ps_out),
        .irq_take(irq_take), .reg_addr(reg_addr)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load_ps(input logic [15:0] val);
        @(negedge clk);
        ps_load  = 1'b1;
        ps_wdata = val;
        @(negedge clk);
        ps_load  = 1'b0;
    endtask

    task automatic alu_step(input logic [2:0] cls, input logic [7:0] a, input logic [7:0] b,
                            input logic [7:0] res, input logic [4:0] we,
                            input string tag, input logic [15:0] exp);
        @(negedge clk);
        alu_cls = cls; alu_a = a; alu_b = b; alu_res = res; flag_we = we;
        @(negedge clk);
        chk(tag, ps_out, exp);
        flag_we = '0;
    endtask

    task automatic irq_step(input logic [1:0] lvl, input logic exp_take,
                            input string tag, input logic [15:0] exp_ps);
        @(negedge clk);
        irq_req = 1'b1; irq_lvl = lvl;
        #2;
        chk({tag, " take"}, {15'b0, irq_take}, {15'b0, exp_take});
        @(negedge clk);
        irq_req = 1'b0;
        chk({tag, " word"}, ps_out, exp_ps);
    endtask

    task automatic t_reset;
        chk("R1 reset word", ps_out, 16'h0030);
        reg_idx = 3'd0;
        #1;
        chk("R1 reset address", reg_addr, 16'h0100);
    endtask

    task automatic t_add;
        load_ps(16'h0000);
        alu_step(C_ADD, 8'h0F, 8'h01, 8'h10, WE_ALL, "R3 add nibble carry", 16'h0080);
        alu_step(C_ADD, 8'h80, 8'h80, 8'h00, WE_ALL, "R3 R5 add carry overflow zero", 16'h0007);
        alu_step(C_ADD, 8'h7F, 8'h01, 8'h80, WE_ALL, "R3 R5 add overflow negative", 16'h008A);
        load_ps(16'h0001);
        alu_step(C_ADC, 8'hFF, 8'h00, 8'h00, WE_ALL, "R3 adc carry in", 16'h0085);
    endtask

    task automatic t_sub;
        alu_step(C_SUB, 8'h10, 8'h01, 8'h0F, WE_ALL, "R4 sub nibble borrow", 16'h0080);
        alu_step(C_SUB, 8'h00, 8'h01, 8'hFF, WE_ALL, "R4 R5 sub borrow out", 16'h0089);
        alu_step(C_SUB, 8'h80, 8'h01, 8'h7F, WE_ALL, "R4 sub overflow", 16'h0082);
        load_ps(16'h0001);
        alu_step(C_SBC, 8'h05, 8'h05, 8'hFF, WE_ALL, "R4 sbc borrow in", 16'h0089);
    endtask

    task automatic t_shift_logic;
        load_ps(16'h0083);
        alu_step(C_SHL, 8'h81, 8'h00, 8'h02, WE_ALL, "R6 shift left", 16'h0001);
        alu_step(C_SHR, 8'h01, 8'h00, 8'h00, WE_ALL, "R6 R5 shift right", 16'h0005);
        load_ps(16'h0083);
        alu_step(C_LOG, 8'hF0, 8'h0F, 8'h00, WE_ALL, "R6 R5 logic zero", 16'h0004);
        alu_step(C_LOG2, 8'hF0, 8'hFF, 8'h80, WE_ALL, "R6 R5 logic negative", 16'h0008);
    endtask

    task automatic t_we;
        load_ps(16'h0000);
        alu_step(C_ADD, 8'h80, 8'h80, 8'h00, 5'h00, "R7 no enables", 16'h0000);
        alu_step(C_ADD, 8'h80, 8'h80, 8'h00, 5'h01, "R7 carry only", 16'h0001);
        load_ps(16'h1270);
        alu_step(C_ADD, 8'h80, 8'h80, 8'h00, 5'h01, "R7 other fields kept", 16'h1271);
        alu_step(C_ADD, 8'h0F, 8'h01, 8'h10, 5'h10, "R7 half carry only", 16'h12F1);
    endtask

    task automatic t_load;
        load_ps(16'hFFFF);
        chk("R2 upper bits read zero", ps_out, 16'h1FFF);
        load_ps(16'h0A5A);
        chk("R2 load pattern", ps_out, 16'h0A5A);
    endtask

    task automatic t_irq;
        load_ps(16'h0020);
        irq_step(2'd0, 1'b0, "R8 disabled ignored", 16'h0020);
        load_ps(16'h0060);
        irq_step(2'd2, 1'b0, "R8 equal level ignored", 16'h0060);
        irq_step(2'd3, 1'b0, "R8 lower priority ignored", 16'h0060);
        irq_step(2'd1, 1'b1, "R8 R9 higher priority taken", 16'h0050);
        irq_step(2'd1, 1'b0, "R9 now blocks same level", 16'h0050);
        irq_step(2'd0, 1'b1, "R9 level zero taken", 16'h0040);
        irq_step(2'd0, 1'b0, "R8 level zero blocks all", 16'h0040);
    endtask

    task automatic t_load_vs_irq;
        load_ps(16'h0070);
        @(negedge clk);
        irq_req = 1'b1; irq_lvl = 2'd1; ps_load = 1'b1; ps_wdata = 16'h0030;
        #2;
        chk("R10 take blocked by load", {15'b0, irq_take}, 16'h0000);
        @(negedge clk);
        irq_req = 1'b0; ps_load = 1'b0;
        chk("R10 loaded value wins", ps_out, 16'h0030);
    endtask

    task automatic t_concurrent;
        load_ps(16'h0070);
        @(negedge clk);
        irq_req = 1'b1; irq_lvl = 2'd2;
        alu_cls = C_ADD; alu_a = 8'h80; alu_b = 8'h80; alu_res = 8'h00; flag_we = 5'h01;
        @(negedge clk);
        irq_req = 1'b0; flag_we = '0;
        chk("R9 level and flag same cycle", ps_out, 16'h0061);
    endtask

    task automatic t_regaddr;
        load_ps(16'h0000);
        reg_idx = 3'd0; #1;
        chk("R11 bank 0 index 0", reg_addr, 16'h0100);
        load_ps(16'h1F00);
        reg_idx = 3'd7; #1;
        chk("R11 bank 31 index 7", reg_addr, 16'h01FF);
        load_ps(16'hE500);
        reg_idx = 3'd3; #1;
        chk("R11 bank 5 index 3", reg_addr, 16'h012B);
        chk("R2 bank load drops top bits", ps_out, 16'h0500);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_add();
        t_sub();
        t_shift_logic();
        t_we();
        t_load();
        t_irq();
        t_load_vs_irq();
        t_concurrent();
        t_regaddr();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1-path run actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule